// File: doc/BRIEF.md
# SECAM Line Sequence Controller

This block produces the per-line control signals that a SECAM chroma encoder needs. It runs on a fast system clock. A single-cycle line-start strobe and a vertical-blanking level drive it. It holds the flag that picks the red or blue colour-difference channel for the current line, and an optional half-line-rate reference can pin that flag so that several encoders stay in step. On each line it stops the FM modulator and later sends it a short restart pulse. It also tracks the subcarrier start phase, which runs on a three-line cycle and is inverted from one field to the next.

During vertical blanking the block opens two calibration windows, one after the other: the first for the red reference oscillator and the second for the blue one. A two-bit tuning-mode input is decoded into separate enables for crystal tuning, line-locked PLL tuning and vertical identification. A colour-kill input is passed on as a chroma blanking command.

Top module: `secam_line_ctrl`

## Requirements
- R1: `chan_red` changes state on every `line_start` pulse (1 = red line, 0 = blue line) when `half_line_ref` is low, so the two channels alternate at half the line rate.
- R2: If `half_line_ref` is high in the cycle of a `line_start` pulse, `chan_red` becomes 1 whatever its previous value. A reference held low leaves the block free-running.
- R3: `phase_flip` (1 = 180 degrees) advances one step on each `line_start`. After reset it reads 0, 0, 1 on the first, second and third line, and the cycle then repeats.
- R4: Each rising edge of `vblank` inverts the phase cycle, so the next field reads 1, 1, 0 where the last read 0, 0, 1.
- R5: In the cycle after a `line_start` sample, `mod_stop` goes high for 15 clocks. `mod_restart` is then high for 4 clocks, beginning 16 clocks after the strobe edge. The two are never high together, and a new strobe restarts the sequence.
- R6: Counting the line whose strobe coincides with or follows the rise of `vblank` as line 1, `cal_red` is high on lines 3 and 4 and `cal_blue` on lines 5 and 6. Both windows are cut off as soon as `vblank` falls, so the full schedule only completes in a blanking interval of at least six lines.
- R7: `tune_mode` 2'b00 gives `xtal_sel`=1, `pll_sel`=0. 2'b01 and 2'b11 give `pll_sel`=1. 2'b10 gives `pll_sel`=1 and `vident_en`=1. `vident_en` is 0 in every other mode.
- R8: `chroma_blank` is high exactly while `colour_kill` is high, which forces both colour-difference channels to zero.
- R9: `gain_red` equals `chan_red` on every line and selects the red gain, which is 280/230 times the blue gain.
- R10: A clock edge with `rst_n` low clears `chan_red` to blue, the phase cycle to its first step with no field inversion, the blanking line count to 0 and every pulse and window to inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| line_start | input | 1 | Single-cycle strobe at each line sync edge |
| vblank | input | 1 | Vertical blanking level |
| half_line_ref | input | 1 | External half-line-rate reference, high on red lines |
| tune_mode | input | 2 | Tuning mode code |
| colour_kill | input | 1 | Colour kill request |
| chan_red | output | 1 | Channel select, 1 = red, 0 = blue |
| gain_red | output | 1 | Gain select, 1 = red gain |
| phase_flip | output | 1 | Start phase, 1 = 180 degrees |
| mod_stop | output | 1 | Modulator stop |
| mod_restart | output | 1 | Modulator restart pulse |
| cal_red | output | 1 | Red reference calibration window |
| cal_blue | output | 1 | Blue reference calibration window |
| xtal_sel | output | 1 | Crystal tuning enable |
| pll_sel | output | 1 | Line-locked PLL tuning enable |
| vident_en | output | 1 | Vertical identification enable |
| chroma_blank | output | 1 | Colour-difference blanking |

## Verification
A wrong channel flag shows as a `chan_red` value that fails to match the expected alternation. It is visible in the cycle after the next line strobe and stays wrong until the half-line reference forces it back. If the phase counter or field-inversion bit is corrupted, the 0/0/180 pattern slips or flips polarity, and this appears within three lines or at the next blanking edge. A faulty blanking line count moves the calibration windows by whole lines, and a faulty pulse counter moves the restart edge by clocks. Both errors are caught by sampling at line and clock offsets worked out from the requirements.

// File: rtl/secam_seq_pkg.sv
// Package: shared encodings for the SECAM line sequence controller.
// Assumes: nothing beyond IEEE 1800-2017.
package secam_seq_pkg;

    // Tuning mode codes carried on the tune_mode port.
    typedef enum logic [1:0] {
        TUNE_XTAL    = 2'b00,
        TUNE_PLL     = 2'b01,
        TUNE_PLL_VID = 2'b10,
        TUNE_PLL_ALT = 2'b11
    } tune_mode_e;

    // Length of the start-phase cycle, in lines.
    localparam int unsigned PHASE_CYCLE = 3;

endpackage

// File: rtl/secam_chan_phase.sv
// Module: channel alternation, gain select and start-phase sequencing.
// Does: toggles the red/blue flag per line (or forces red when the
// half-line reference is high), steps a modulo-PHASE_CYCLE counter per
// line and inverts the phase pattern at each blanking rise.
// Assumes: line_start and vb_rise are single-cycle pulses.
module secam_chan_phase
    import secam_seq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic vb_rise,
    input  logic half_line_ref,
    output logic chan_red,
    output logic gain_red,
    output logic phase_flip
);

    localparam int unsigned PW = $clog2(PHASE_CYCLE);
    localparam logic [PW-1:0] PH_LAST = PW'(PHASE_CYCLE - 1);

    logic [PW-1:0] ph_q;
    logic          field_inv_q;

    // Channel flag and gain select: forced red by reference, else toggled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_red <= 1'b0;
            gain_red <= 1'b0;
        end else if (line_start) begin
            chan_red <= half_line_ref ? 1'b1 : ~chan_red;
            gain_red <= half_line_ref ? 1'b1 : ~gain_red;
        end
    end

    // Phase counter: one step per line, wraps after PHASE_CYCLE lines.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ph_q <= '0;
        else if (line_start)
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    end

    // Field inversion bit: flips at each blanking rise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            field_inv_q <= 1'b0;
        else if (vb_rise)
            field_inv_q <= ~field_inv_q;
    end

    // Start phase: last step of the cycle is 180 degrees, then field inversion.
    assign phase_flip = (ph_q == PH_LAST) ^ field_inv_q;

    // R1: free-running alternation flips the channel.
    a_r1_chan_toggles: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && !half_line_ref) |=> (chan_red != $past(chan_red)));

    // R2: reference high at line start forces red.
    a_r2_ref_forces_red: assert property (@(posedge clk) disable iff (!rst_n)
        (line_start && half_line_ref) |=> chan_red);

    // R3: counter never leaves its cycle.
    a_r3_phase_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q <= PH_LAST);

    // R4: each blanking rise inverts the field bit.
    a_r4_field_inverts: assert property (@(posedge clk) disable iff (!rst_n)
        vb_rise |=> (field_inv_q != $past(field_inv_q)));

    // R9: gain select tracks the channel.
    a_r9_gain_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        line_start |=> (gain_red == chan_red));

endmodule

// File: rtl/secam_line_pulse.sv
// Module: modulator stop/restart pulse shaper.
// Does: after each line strobe holds stop for STOP_CLKS-1 clocks, then
// restart for RESTART_CLKS clocks, timed from the strobe edge.
// Assumes: STOP_CLKS >= 2 and RESTART_CLKS >= 1.
module secam_line_pulse #(
    parameter int unsigned STOP_CLKS    = 16,
    parameter int unsigned RESTART_CLKS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    output logic mod_stop,
    output logic mod_restart
);

    localparam int unsigned TOTAL = STOP_CLKS + RESTART_CLKS;
    localparam int unsigned CW    = $clog2(TOTAL);
    localparam logic [CW-1:0] C_RST  = CW'(STOP_CLKS);
    localparam logic [CW-1:0] C_LAST = CW'(TOTAL - 1);

    logic [CW-1:0] cnt_q;

    // Clock counter since the last strobe; zero when idle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (line_start)
            cnt_q <= CW'(1);
        else if (cnt_q != '0)
            cnt_q <= (cnt_q == C_LAST) ? '0 : cnt_q + 1'b1;
    end

    // Pulse decode from the counter.
    assign mod_stop    = (cnt_q != '0) && (cnt_q < C_RST);
    assign mod_restart = (cnt_q >= C_RST);

    // R5: stop and restart never overlap.
    a_r5_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(mod_stop && mod_restart));

    // R5: restart only ever follows a stop period.
    a_r5_restart_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mod_restart) |-> $past(mod_stop));

endmodule

// File: rtl/secam_vb_cal.sv
// Module: calibration window scheduler inside vertical blanking.
// Does: counts lines since blanking began and opens the red window for
// CAL_LINES lines from FIRST_LINE, then the blue window for CAL_LINES.
// Assumes: vblank is a level stable across a line.
module secam_vb_cal #(
    parameter int unsigned FIRST_LINE = 3,
    parameter int unsigned CAL_LINES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_start,
    input  logic vblank,
    output logic cal_red,
    output logic cal_blue
);

    localparam int unsigned SAT_LINE = FIRST_LINE + 2 * CAL_LINES;
    localparam int unsigned LW       = $clog2(SAT_LINE + 1);
    localparam logic [LW-1:0] L_SAT   = LW'(SAT_LINE);
    localparam logic [LW-1:0] L_RED   = LW'(FIRST_LINE);
    localparam logic [LW-1:0] L_BLUE  = LW'(FIRST_LINE + CAL_LINES);
    localparam logic [LW-1:0] L_END   = LW'(FIRST_LINE + 2 * CAL_LINES);

    logic [LW-1:0] line_q;

    // Blanking line counter: cleared outside blanking, saturates after schedule.
    always_ff @(posedge clk) begin
        if (!rst_n)
            line_q <= '0;
        else if (!vblank)
            line_q <= '0;
        else if (line_start && line_q != L_SAT)
            line_q <= line_q + 1'b1;
    end

    // Window decode, cut off the moment blanking ends.
    assign cal_red  = vblank && (line_q >= L_RED)  && (line_q < L_BLUE);
    assign cal_blue = vblank && (line_q >= L_BLUE) && (line_q < L_END);

    // R6: the two windows are exclusive.
    a_r6_windows_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(cal_red && cal_blue));

    // R6: windows exist only inside blanking.
    a_r6_window_in_blank: assert property (@(posedge clk) disable iff (!rst_n)
        (cal_red || cal_blue) |-> vblank);

    // R6: blue window opens only straight after the red one.
    a_r6_blue_after_red: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_blue) |-> $past(cal_red));

endmodule

// File: rtl/secam_line_ctrl.sv
// Module: top of the SECAM line sequence controller.
// Does: detects the blanking rise, instantiates the channel/phase,
// pulse and calibration submodules, and decodes tuning mode and colour kill.
// Assumes: line_start is a single-cycle strobe in the clk domain.
module secam_line_ctrl
    import secam_seq_pkg::*;
#(
    parameter int unsigned STOP_CLKS    = 16,
    parameter int unsigned RESTART_CLKS = 4,
    parameter int unsigned CAL_FIRST    = 3,
    parameter int unsigned CAL_LINES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_start,
    input  logic       vblank,
    input  logic       half_line_ref,
    input  logic [1:0] tune_mode,
    input  logic       colour_kill,
    output logic       chan_red,
    output logic       gain_red,
    output logic       phase_flip,
    output logic       mod_stop,
    output logic       mod_restart,
    output logic       cal_red,
    output logic       cal_blue,
    output logic       xtal_sel,
    output logic       pll_sel,
    output logic       vident_en,
    output logic       chroma_blank
);

    logic vb_d;
    logic vb_rise;

    // Delayed blanking level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            vb_d <= 1'b0;
        else
            vb_d <= vblank;
    end

    assign vb_rise = vblank && !vb_d;

    secam_chan_phase u_chan (
        .clk           (clk),
        .rst_n         (rst_n),
        .line_start    (line_start),
        .vb_rise       (vb_rise),
        .half_line_ref (half_line_ref),
        .chan_red      (chan_red),
        .gain_red      (gain_red),
        .phase_flip    (phase_flip)
    );

    secam_line_pulse #(
        .STOP_CLKS    (STOP_CLKS),
        .RESTART_CLKS (RESTART_CLKS)
    ) u_pulse (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_start  (line_start),
        .mod_stop    (mod_stop),
        .mod_restart (mod_restart)
    );

    secam_vb_cal #(
        .FIRST_LINE (CAL_FIRST),
        .CAL_LINES  (CAL_LINES)
    ) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_start (line_start),
        .vblank     (vblank),
        .cal_red    (cal_red),
        .cal_blue   (cal_blue)
    );

    // Tuning mode decode into one-hot style enables.
    always_comb begin
        xtal_sel  = 1'b0;
        pll_sel   = 1'b0;
        vident_en = 1'b0;
        case (tune_mode_e'(tune_mode))
            TUNE_XTAL:    xtal_sel = 1'b1;
            TUNE_PLL_VID: begin
                pll_sel   = 1'b1;
                vident_en = 1'b1;
            end
            default:      pll_sel = 1'b1;
        endcase
    end

    // Colour kill passes straight to the chroma blanking command.
    assign chroma_blank = colour_kill;

    // R7: vertical identification only with PLL tuning.
    a_r7_vident_needs_pll: assert property (@(posedge clk) disable iff (!rst_n)
        vident_en |-> (pll_sel && !xtal_sel));

    // R7: exactly one tuning source is selected.
    a_r7_one_source: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({xtal_sel, pll_sel}) == 1);

endmodule

// File: tb/secam_line_ctrl_bench.sv
// Bench: table-driven line sequence, then directed pulse, decode and reset tests.
module secam_line_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LINE_GAP   = 30;
    localparam int N_VEC      = 19;

    // Each entry: {vblank, half_line_ref, exp_chan, exp_phase, exp_cal_red, exp_cal_blue}
    localparam logic [5:0] VEC [N_VEC] = '{
        6'b001000, 6'b000100, 6'b011000, 6'b000000, 6'b001100,
        6'b011000, 6'b100100, 6'b101000, 6'b100110, 6'b101110,
        6'b100001, 6'b101101, 6'b100100, 6'b001000, 6'b000100,
        6'b101000, 6'b100100, 6'b101010, 6'b000000
    };

    logic clk = 1'b0;
    logic rst_n, line_start, vblank, half_line_ref, colour_kill;
    logic [1:0] tune_mode;
    logic chan_red, gain_red, phase_flip, mod_stop, mod_restart;
    logic cal_red, cal_blue, xtal_sel, pll_sel, vident_en, chroma_blank;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    secam_line_ctrl u_secam_line_ctrl (
        .clk (clk), .rst_n (rst_n), .line_start (line_start), .vblank (vblank),
        .half_line_ref (half_line_ref), .tune_mode (tune_mode),
        .colour_kill (colour_kill), .chan_red (chan_red), .gain_red (gain_red),
        .phase_flip (phase_flip), .mod_stop (mod_stop), .mod_restart (mod_restart),
        .cal_red (cal_red), .cal_blue (cal_blue), .xtal_sel (xtal_sel),
        .pll_sel (pll_sel), .vident_en (vident_en), .chroma_blank (chroma_blank)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One line: strobe with the given blanking and reference levels.
    task automatic do_line(input logic v, input logic e);
        @(negedge clk);
        vblank = v; half_line_ref = e; line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0; half_line_ref = 1'b0;
        repeat (LINE_GAP) @(negedge clk);
    endtask

    initial begin
        rst_n = 1'b0; line_start = 1'b0; vblank = 1'b0; half_line_ref = 1'b0;
        tune_mode = 2'b01; colour_kill = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        chk("R10 chan", {7'd0, chan_red}, 8'd0);
        chk("R10 phase", {7'd0, phase_flip}, 8'd0);
        chk("R10 pulses", {6'd0, mod_stop, mod_restart}, 8'd0);
        chk("R10 windows", {6'd0, cal_red, cal_blue}, 8'd0);

        // R1 R2 R3 R4 R6 R9: table walk
        for (int i = 0; i < N_VEC; i++) begin
            do_line(VEC[i][5], VEC[i][4]);
            chk($sformatf("R1/R2 chan line %0d", i + 1), {7'd0, chan_red}, {7'd0, VEC[i][3]});
            chk($sformatf("R9 gain line %0d", i + 1), {7'd0, gain_red}, {7'd0, VEC[i][3]});
            chk($sformatf("R3/R4 phase line %0d", i + 1), {7'd0, phase_flip}, {7'd0, VEC[i][2]});
            chk($sformatf("R6 windows line %0d", i + 1), {6'd0, cal_red, cal_blue},
                {6'd0, VEC[i][1], VEC[i][0]});
        end

        // R5: stop/restart timing from the strobe edge
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        chk("R5 stop at +1", {6'd0, mod_stop, mod_restart}, 8'b10);
        repeat (14) @(negedge clk);
        chk("R5 stop at +15", {6'd0, mod_stop, mod_restart}, 8'b10);
        @(negedge clk);
        chk("R5 restart at +16", {6'd0, mod_stop, mod_restart}, 8'b01);
        repeat (3) @(negedge clk);
        chk("R5 restart at +19", {6'd0, mod_stop, mod_restart}, 8'b01);
        @(negedge clk);
        chk("R5 idle at +20", {6'd0, mod_stop, mod_restart}, 8'b00);

        // R7: mode decode
        for (int m = 0; m < 4; m++) begin
            tune_mode = 2'(m);
            @(negedge clk);
            chk($sformatf("R7 mode %0d", m), {5'd0, xtal_sel, pll_sel, vident_en},
                (m == 0) ? 8'b100 : (m == 2) ? 8'b011 : 8'b010);
        end

        // R8: colour kill
        colour_kill = 1'b1;
        @(negedge clk);
        chk("R8 kill on", {7'd0, chroma_blank}, 8'd1);
        colour_kill = 1'b0;
        @(negedge clk);
        chk("R8 kill off", {7'd0, chroma_blank}, 8'd0);

        // R10: reset mid-run inside blanking and during a stop period
        do_line(1'b1, 1'b0);
        do_line(1'b1, 1'b0);
        do_line(1'b1, 1'b0);
        chk("R6 red window before reset", {7'd0, cal_red}, 8'd1);
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk("R10 chan after reset", {7'd0, chan_red}, 8'd0);
        chk("R10 phase after reset", {7'd0, phase_flip}, 8'd0);
        chk("R10 stop cleared", {6'd0, mod_stop, mod_restart}, 8'd0);
        chk("R10 windows cleared", {6'd0, cal_red, cal_blue}, 8'd0);
        vblank = 1'b0;
        repeat (2) @(negedge clk);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

endmodule